// File: doc/BRIEF.md
# Fault Status and Interrupt Controller

This block collects level fault signals from monitoring circuits into banks of status bits and presents them to a host. A fault is latched on its rising edge into a status bit. The bit stays set until the host reads the bank that holds it. Each bank has an enable register. The enables decide only whether a latched bit drives the active-low interrupt output. They never stop a bit from latching, and they have no effect on the any-pending flag.

A read of a bank returns its contents and clears it. A toggle of the wake input, in either direction, clears every bank. Every clear starts a hold-off timer for the cleared bank. The timer is a prescaler counter followed by a tick counter. When it expires, every fault of that bank that is still high is latched again. This way the interrupt comes back within a bounded time for a persistent fault, while the host cannot be held in a tight loop.

Top module: `fault_irq_ctl`

## Requirements
- R1: After reset, all status bits are 0, `irq_n_o` is 1, `pending_o` is 0, `rd_data_o` is 0, and every enable bit is 1.
- R2: A rising edge on `fault_i[b*W+i]` sets bit i of bank b at the next clock edge.
- R3: `irq_n_o` is 0 exactly when some status bit is set and its enable bit is 1.
- R4: `pending_o` is 1 exactly when any status bit is set, whatever the enables are.
- R5: A read strobe with `rd_sel_i` = b puts the contents of bank b on `rd_data_o` one cycle later, clears bank b, and leaves the other banks unchanged.
- R6: A fault edge in the same cycle as a clearing read or wake toggle of its bank leaves its bit set.
- R7: Clearing an enable bit masks that bit from `irq_n_o`, but the status bit still latches and still reads back.
- R8: Any change of `wake_i` clears all status bits at the next clock edge.
- R9: After a clear, a fault of that bank that is still high is latched again exactly PRESC*TICKS cycles after the clearing edge, and not before.
- R10: A fault that has gone low by the time the hold-off timer expires is not latched again.
- R11: A write strobe loads `wr_data_i` into the enable register of bank `wr_sel_i` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fault_i | input | NREG*W | Level fault inputs; bank b uses bits b*W to b*W+W-1 |
| rd_en_i | input | 1 | Read strobe (read and clear) |
| rd_sel_i | input | $clog2(NREG) | Bank to read |
| wr_en_i | input | 1 | Enable register write strobe |
| wr_sel_i | input | $clog2(NREG) | Bank whose enable register is written |
| wr_data_i | input | W | New enable value |
| wake_i | input | 1 | Wake input; any change clears all status |
| rd_data_o | output | W | Status read data, valid the cycle after the strobe |
| irq_n_o | output | 1 | Active-low interrupt, gated by the enables |
| pending_o | output | 1 | Any status bit set, ignoring the enables |

## Verification
The hardest case to reach is the timed re-latch. It needs a fault held high across a clearing read, and then an exact count of cycles until the status bit comes back. The bench uses a small prescaler and tick count for this. It holds the fault, reads the bank, and then samples `pending_o` after every following edge. The bit must stay clear until edge PRESC*TICKS and must be set on that edge. A second pass drops the fault together with the read and waits well past expiry. Collisions between an event and a clearing read are driven in the same cycle from the vector table.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic logic level_changed(input logic now_v, input logic prev_v);
        return now_v ^ prev_v;
    endfunction

endpackage

// File: rtl/relatch_timer.sv
module relatch_timer
    import fault_irq_pkg::*;
#(
    parameter int PRESC = 100,
    parameter int TICKS = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic expire_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam int TW = $clog2(TICKS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESC - 1);
    localparam logic [TW-1:0] TICK_LOAD = TW'(TICKS);

    tmr_state_e    state_q;
    logic [PW-1:0] pre_q;
    logic [TW-1:0] tick_q;
    logic          pre_wrap;

    assign pre_wrap = (pre_q == PRE_LAST);
    assign expire_o = (state_q == TMR_RUN) && pre_wrap && (tick_q == TW'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= TMR_IDLE;
            pre_q   <= '0;
            tick_q  <= '0;
        end else if (start_i) begin
            state_q <= TMR_RUN;
            pre_q   <= '0;
            tick_q  <= TICK_LOAD;
        end else if (state_q == TMR_RUN) begin
            if (pre_wrap) begin
                pre_q  <= '0;
                tick_q <= tick_q - TW'(1);
                if (tick_q == TW'(1)) begin
                    state_q <= TMR_IDLE;
                end
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/fault_bank.sv
module fault_bank
    import fault_irq_pkg::*;
#(
    parameter int W     = 8,
    parameter int PRESC = 100,
    parameter int TICKS = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] fault_i,
    input  logic         clr_i,
    input  logic         en_wr_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] set_o
);
    logic [W-1:0] fault_q;
    logic         expire;

    relatch_timer #(.PRESC(PRESC), .TICKS(TICKS)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (clr_i),
        .expire_o (expire)
    );

    // New events: rising edges, plus held levels when the hold-off ends.
    assign set_o = (fault_i & ~fault_q) | (expire ? fault_i : '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fault_q  <= '0;
            status_o <= '0;
            en_o     <= '1;
        end else begin
            fault_q  <= fault_i;
            status_o <= (status_o & ~{W{clr_i}}) | set_o;
            if (en_wr_i) begin
                en_o <= en_wdata_i;
            end
        end
    end
endmodule

// File: rtl/fault_irq_ctl.sv
module fault_irq_ctl
    import fault_irq_pkg::*;
#(
    parameter int W     = 8,
    parameter int NREG  = 2,
    parameter int PRESC = 100,
    parameter int TICKS = 32,
    localparam int SELW = $clog2(NREG),
    localparam int FW   = NREG * W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [FW-1:0]   fault_i,
    input  logic            rd_en_i,
    input  logic [SELW-1:0] rd_sel_i,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  logic [W-1:0]    wr_data_i,
    input  logic            wake_i,
    output logic [W-1:0]    rd_data_o,
    output logic            irq_n_o,
    output logic            pending_o
);
    logic [W-1:0]  st_arr [NREG];
    logic [FW-1:0] st_flat;
    logic [FW-1:0] en_flat;
    logic [FW-1:0] set_flat;
    logic          wake_q;
    logic          wake_tgl;

    assign wake_tgl = level_changed(wake_i, wake_q);

    for (genvar b = 0; b < NREG; b++) begin : g_bank
        logic clr;
        logic en_wr;
        assign clr   = wake_tgl || (rd_en_i && (rd_sel_i == SELW'(b)));
        assign en_wr = wr_en_i && (wr_sel_i == SELW'(b));

        fault_bank #(.W(W), .PRESC(PRESC), .TICKS(TICKS)) u_bank (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .fault_i    (fault_i[b*W +: W]),
            .clr_i      (clr),
            .en_wr_i    (en_wr),
            .en_wdata_i (wr_data_i),
            .status_o   (st_arr[b]),
            .en_o       (en_flat[b*W +: W]),
            .set_o      (set_flat[b*W +: W])
        );
        assign st_flat[b*W +: W] = st_arr[b];
    end

    assign irq_n_o   = ~|(st_flat & en_flat);
    assign pending_o = |st_flat;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wake_q    <= 1'b0;
            rd_data_o <= '0;
        end else begin
            wake_q <= wake_i;
            if (rd_en_i) begin
                rd_data_o <= st_arr[rd_sel_i];
            end
        end
    end
endmodule

// File: rtl/fault_irq_ctl_chk.sv
module fault_irq_ctl_chk #(
    parameter int W    = 8,
    parameter int NREG = 2,
    localparam int SELW = $clog2(NREG),
    localparam int FW   = NREG * W
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            rd_en_i,
    input logic [SELW-1:0] rd_sel_i,
    input logic            wr_en_i,
    input logic [SELW-1:0] wr_sel_i,
    input logic [W-1:0]    wr_data_i,
    input logic [W-1:0]    rd_data_o,
    input logic            irq_n_o,
    input logic            pending_o,
    input logic [FW-1:0]   st_flat,
    input logic [FW-1:0]   en_flat,
    input logic [FW-1:0]   set_flat,
    input logic            wake_tgl
);
    logic [W-1:0]    rd_view;
    logic [SELW-1:0] wsel_q;

    assign rd_view = st_flat[int'(rd_sel_i)*W +: W];

    always_ff @(posedge clk_i) begin
        wsel_q <= wr_sel_i;
    end

    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !pending_o |-> irq_n_o);

    // R5
    read_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i |=> rd_data_o == $past(rd_view));

    // R6
    event_kept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (set_flat != '0) |=> (st_flat & $past(set_flat)) == $past(set_flat));

    // R8
    wake_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wake_tgl && set_flat == '0) |=> st_flat == '0);

    // R11
    en_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> en_flat[int'(wsel_q)*W +: W] == $past(wr_data_i));
endmodule

bind fault_irq_ctl fault_irq_ctl_chk #(.W(W), .NREG(NREG)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_n_o   (irq_n_o),
    .pending_o (pending_o),
    .st_flat   (st_flat),
    .en_flat   (en_flat),
    .set_flat  (set_flat),
    .wake_tgl  (wake_tgl)
);

// File: tb/test_fault_irq_ctl.sv
`timescale 1ns/1ps
module test_fault_irq_ctl;
    localparam int W     = 8;
    localparam int NREG  = 2;
    localparam int PRESC = 4;
    localparam int TICKS = 3;
    localparam int D     = PRESC * TICKS;
    localparam int NV    = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   fault = '0;
    logic          rd_en = 1'b0;
    logic          rd_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          wake = 1'b0;
    logic [7:0]    rd_data;
    logic          irq_n;
    logic          pending;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fault_irq_ctl #(.W(W), .NREG(NREG), .PRESC(PRESC), .TICKS(TICKS)) i_fault_irq_ctl (
        .clk_i     (clk),
        .rst_i     (rst),
        .fault_i   (fault),
        .rd_en_i   (rd_en),
        .rd_sel_i  (rd_sel),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .wake_i    (wake),
        .rd_data_o (rd_data),
        .irq_n_o   (irq_n),
        .pending_o (pending)
    );

    // {fault[15:0], rd_en, rd_sel, exp_pending, exp_irq_n, exp_rd[7:0]}
    localparam logic [27:0] VEC [NV] = '{
        {16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R2 bank0 bit0
        {16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01},  // R5 read clears
        {16'h0300, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R2 bank1 bits0,1
        {16'h0300, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},  // R5 other bank kept
        {16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 8'h03},  // R5 bank1 read
        {16'h0080, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},  // R6 collision
        {16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80},  // R6 bit survived
        {16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R2 bank1 bit7
        {16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80}   // R5 bank1 bit7
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel);
        rd_en  = 1'b1;
        rd_sel = sel;
        cyc();
        rd_en  = 1'b0;
    endtask

    task automatic wen(input logic sel, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        cyc();
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc();
        cyc();
        rst = 1'b0;
        // R1 reset state
        chk("R1 pending", {7'b0, pending}, 8'h00);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 rd_data", rd_data, 8'h00);

        for (int v = 0; v < NV; v++) begin
            fault  = VEC[v][27:12];
            rd_en  = VEC[v][11];
            rd_sel = VEC[v][10];
            cyc();
            chk($sformatf("R2/R3/R4 vec%0d pending", v), {7'b0, pending}, {7'b0, VEC[v][9]});
            chk($sformatf("R3 vec%0d irq_n", v), {7'b0, irq_n}, {7'b0, VEC[v][8]});
            if (VEC[v][11]) chk($sformatf("R5/R6 vec%0d rd_data", v), rd_data, VEC[v][7:0]);
        end
        fault = '0;
        rd_en = 1'b0;
        repeat (3 * D) cyc();

        // R7 / R11: mask bank0 bit0
        wen(1'b0, 8'hFE);
        fault = 16'h0001;
        cyc();
        chk("R7 masked irq_n", {7'b0, irq_n}, 8'h01);
        chk("R4 pending ignores mask", {7'b0, pending}, 8'h01);
        fault = 16'h0003;
        cyc();
        chk("R3 enabled bit irq_n", {7'b0, irq_n}, 8'h00);
        fault = '0;
        rd(1'b0);
        chk("R7 masked bit latched", rd_data, 8'h03);
        chk("R3 released irq_n", {7'b0, irq_n}, 8'h01);
        wen(1'b0, 8'hFF);
        repeat (3 * D) cyc();

        // R8 wake rise clears both banks
        fault = 16'h0804;
        cyc();
        chk("R8 setup pending", {7'b0, pending}, 8'h01);
        fault = '0;
        wake = 1'b1;
        cyc();
        chk("R8 wake rise pending", {7'b0, pending}, 8'h00);
        rd(1'b0);
        chk("R8 bank0 cleared", rd_data, 8'h00);
        rd(1'b1);
        chk("R8 bank1 cleared", rd_data, 8'h00);
        // R8 wake fall also clears
        fault = 16'h1000;
        cyc();
        fault = '0;
        wake = 1'b0;
        cyc();
        chk("R8 wake fall pending", {7'b0, pending}, 8'h00);
        repeat (3 * D) cyc();

        // R9 persistent fault re-latch after exactly D cycles
        fault = 16'h0010;
        cyc();
        chk("R9 setup pending", {7'b0, pending}, 8'h01);
        rd(1'b0);
        chk("R9 first read", rd_data, 8'h10);
        begin
            bit early = 1'b0;
            for (int k = 1; k < D; k++) begin
                cyc();
                if (pending) early = 1'b1;
            end
            chk("R9 no early relatch", {7'b0, early}, 8'h00);
        end
        cyc();
        chk("R9 relatch pending", {7'b0, pending}, 8'h01);
        chk("R9 relatch irq_n", {7'b0, irq_n}, 8'h00);

        // R10 fault gone at expiry
        fault = '0;
        rd(1'b0);
        chk("R10 read", rd_data, 8'h10);
        repeat (3 * D) cyc();
        chk("R10 no relatch", {7'b0, pending}, 8'h00);

        // R1 reset again with a set bit
        fault = 16'h0200;
        cyc();
        rst = 1'b1;
        cyc();
        chk("R1 reset pending", {7'b0, pending}, 8'h00);
        chk("R1 reset irq_n", {7'b0, irq_n}, 8'h01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule